// File: doc/BRIEF.md
# Binary-Weighted Staircase Gate Sequencer

This block drives the switches of one phase leg built from three cascaded single-phase H-bridges whose DC links stand in the ratio 1 : 2 : 4. A phase accumulator advances by a programmable increment each enabled clock and so marks the position inside the fundamental period. A small built-in table holds four sets of seven ascending step angles, one set per modulation index. The active set decides where the output magnitude climbs one unit within the first quarter of the period. Every output level between -7 and +7 units of the smallest DC link can be produced.

The magnitude is mirrored about the quarter-period point, and in the second half of the period its sign is inverted. The resulting signed level is split across the bridges in binary: bit b of the magnitude turns on bridge b, and the half of the period sets the polarity. Each bridge's three-state output is then encoded as four gate bits. A new table row is taken only where the output crosses zero, so a change of modulation index never disturbs a half cycle that is already running. With the enable low, the accumulator is held at zero and every bridge is parked in its zero state.

Top module: `stair_gate_seq`

## Requirements
- R1: During and right after reset, level_o is 0, every bridge's gate nibble is the zero code 4'b1100, the accumulator is 0 and table row 0 is active.
- R2: Bridge b (weight 2^b) drives gates_o[4b+3:4b] with bit0=S1 upper-left, bit1=S2 upper-right, bit2=S3 lower-left, bit3=S4 lower-right. The codes are +1 = 4'b1001, -1 = 4'b0110 and 0 = 4'b1100 (both lower switches on), and no other code ever appears.
- R3: In every cycle, the sum over the bridges of 2^b times the bridge's signed output equals level_o.
- R4: In each enabled cycle the accumulator advances by phase_inc modulo 2^PHASE_W. In the first quarter (phase below 2^(PHASE_W-2)), the level equals the number of angles of the active row that are less than or equal to the phase. Angles are stored as floor(deg*2^PHASE_W/360). Rows 0..3 are: {16.10,23.72,35.19,50.34,54.22,62.67,67.40}, {9.54,20.07,26.70,39.37,52.34,58.38,67.49}, {3.37,15.55,23.12,32.06,44.56,53.64,69.16} and {7.22,13.07,20.85,27.75,39.13,54.53,62.72} degrees.
- R5: In the second quarter, the magnitude at position p equals the magnitude at position 2^(PHASE_W-1) - p.
- R6: When the phase MSB is 1, the level is the negative of the magnitude computed from the lower PHASE_W-1 phase bits.
- R7: row_sel is loaded into the active row only on a step where the phase MSB changes, or while enable is low. A change of row_sel at any other time has no effect on the level until that point.
- R8: While en is low, the accumulator is cleared, level_o is 0 and all bridges show the zero code from the next cycle on. When en rises, the phase restarts from 0.
- R9: With an increment small enough that every level is visited, each half period shows 14 state changes on bridge 0, 6 on bridge 1 and 2 on bridge 2.
- R10: level_o always lies within -7..+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks all bridges at zero |
| phase_inc | input | PHASE_W | Accumulator increment per clock |
| row_sel | input | 2 | Modulation-index table row request |
| gates_o | output | 12 | Four gate bits per bridge, bridge 0 in the low nibble |
| level_o | output | 4 | Signed staircase level in units of the smallest DC link |

## Verification
Two events can land on the same clock edge: a table-row request and the phase crossing between half periods. Only in that case is the new row applied at once. The bench moves row_sel in the middle of a quarter and lets it ride to the crossing. It checks explicitly that the old row's magnitude still holds at 60 degrees, and that the new row's magnitude holds at 240 degrees. Dropping enable mid-period brings the cleared accumulator and the forced zero state together with a row load. The result is judged against a cycle-exact arithmetic model of phase, row and level.

// File: rtl/stair_gate_seq.sv
module stair_gate_seq #(
  parameter int PHASE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [PHASE_W-1:0]  phase_inc,
  input  logic [1:0]          row_sel,
  output logic [11:0]         gates_o,
  output logic signed [3:0]   level_o
);
  localparam int STEPS   = 7;
  localparam int BRIDGES = 3;
  localparam logic [PHASE_W-1:0] HALF_V = PHASE_W'(1) << (PHASE_W - 1);
  localparam logic [3:0] G_POS  = 4'b1001;
  localparam logic [3:0] G_NEG  = 4'b0110;
  localparam logic [3:0] G_ZERO = 4'b1100;
  localparam int DEG100 [4][STEPS] = '{
    '{1610, 2372, 3519, 5034, 5422, 6267, 6740},
    '{ 954, 2007, 2670, 3937, 5234, 5838, 6749},
    '{ 337, 1555, 2312, 3206, 4456, 5364, 6916},
    '{ 722, 1307, 2085, 2775, 3913, 5453, 6272}
  };

  function automatic logic [PHASE_W-1:0] angle(input logic [1:0] r, input int k);
    longint t;
    t = longint'(DEG100[r][k]) * (longint'(1) << PHASE_W) / 36000;
    return t[PHASE_W-1:0];
  endfunction

  logic [PHASE_W-1:0] phase_q, phase_d, fold;
  logic [1:0]         row_q, row_d;
  logic [PHASE_W-2:0] pos;
  logic [2:0]         mag;
  logic signed [3:0]  level_d;
  logic [11:0]        gates_d;
  logic               neg;

  assign phase_d = en ? phase_q + phase_inc : '0;
  assign neg     = phase_d[PHASE_W-1];
  assign row_d   = (!en || (neg != phase_q[PHASE_W-1])) ? row_sel : row_q;
  assign pos     = phase_d[PHASE_W-2:0];
  assign fold    = pos[PHASE_W-2] ? HALF_V - {1'b0, pos} : {1'b0, pos};

  always_comb begin
    mag = '0;
    for (int k = 0; k < STEPS; k++)
      if (fold >= angle(row_d, k)) mag = mag + 3'd1;
  end

  assign level_d = !en ? 4'sd0 : (neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag}));

  for (genvar b = 0; b < BRIDGES; b++) begin : g_bridge
    assign gates_d[4*b +: 4] = (!en || !mag[b]) ? G_ZERO : (neg ? G_NEG : G_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      row_q   <= '0;
      level_o <= '0;
      gates_o <= {BRIDGES{G_ZERO}};
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      level_o <= level_d;
      gates_o <= gates_d;
    end
  end
endmodule

// File: rtl/stair_gate_seq_chk.sv
module stair_gate_seq_chk (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [11:0]       gates,
  input logic signed [3:0] level,
  input logic              phase_msb,
  input logic [1:0]        row
);
  function automatic int contrib(input logic [3:0] c);
    case (c)
      4'b1001: return 1;
      4'b0110: return -1;
      default: return 0;
    endcase
  endfunction

  int wsum;
  always_comb wsum = contrib(gates[3:0]) + 2 * contrib(gates[7:4]) + 4 * contrib(gates[11:8]);

  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (gates[3:0] inside {4'b1001, 4'b0110, 4'b1100}) &&
    (gates[7:4] inside {4'b1001, 4'b0110, 4'b1100}) &&
    (gates[11:8] inside {4'b1001, 4'b0110, 4'b1100}));

  // R3
  weight_sum_chk: assert property (@(posedge clk) disable iff (rst) wsum == int'(level));

  // R6
  half_sign_chk: assert property (@(posedge clk) disable iff (rst)
    phase_msb |-> level <= 4'sd0);

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && phase_msb == $past(phase_msb)) |-> row == $past(row));

  // R8
  park_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (level == 4'sd0 && gates == 12'hCCC && !phase_msb));

  // R10
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    level >= -4'sd7 && level <= 4'sd7);
endmodule

bind stair_gate_seq stair_gate_seq_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .gates(gates_o), .level(level_o),
  .phase_msb(phase_q[PHASE_W-1]), .row(row_q)
);

// File: tb/sim_stair_gate_seq.sv
module sim_stair_gate_seq;
  logic clk = 0, rst = 1, en = 0;
  logic [15:0] inc = 16'd64;
  logic [1:0] idx = 2'd0;
  logic [11:0] gates;
  logic signed [3:0] lvl_o;

  stair_gate_seq u0 (.clk(clk), .rst(rst), .en(en), .phase_inc(inc),
                     .row_sel(idx), .gates_o(gates), .level_o(lvl_o));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int ph = 0, row = 0, exp_lvl = 0;
  int tcnt [3];
  logic [3:0] prevc [3];
  bit count_on = 0, finished = 0;

  localparam int DEGT [4][7] = '{
    '{1610, 2372, 3519, 5034, 5422, 6267, 6740},
    '{ 954, 2007, 2670, 3937, 5234, 5838, 6749},
    '{ 337, 1555, 2312, 3206, 4456, 5364, 6916},
    '{ 722, 1307, 2085, 2775, 3913, 5453, 6272}};

  function automatic int lvl_of(int p, int r);
    int x, q, m;
    x = p % 32768;
    q = (x >= 16384) ? 32768 - x : x;
    m = 0;
    for (int k = 0; k < 7; k++) if (q >= DEGT[r][k] * 65536 / 36000) m++;
    return (p >= 32768) ? -m : m;
  endfunction

  function automatic int contrib(logic [3:0] c);
    case (c)
      4'b1001: return 1;
      4'b0110: return -1;
      4'b1100: return 0;
      default: return 99;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic step();
    int nph, sum;
    bit en_s, crossed;
    @(posedge clk);
    en_s = en;
    nph = en_s ? (ph + int'(inc)) % 65536 : 0;
    crossed = (nph / 32768) != (ph / 32768);
    if (!en_s || crossed) row = int'(idx);
    ph = nph;
    exp_lvl = en_s ? lvl_of(ph, row) : 0;
    @(negedge clk);
    if (ph >= 32768) check(int'(lvl_o) == exp_lvl, "R6", int'(lvl_o), exp_lvl);
    else if (ph >= 16384) check(int'(lvl_o) == exp_lvl, "R5", int'(lvl_o), exp_lvl);
    else check(int'(lvl_o) == exp_lvl, "R4", int'(lvl_o), exp_lvl);
    sum = 0;
    for (int b = 0; b < 3; b++) begin
      check(contrib(gates[4*b +: 4]) != 99, "R2", int'(gates[4*b +: 4]), 12);
      sum += contrib(gates[4*b +: 4]) << b;
    end
    check(sum == int'(lvl_o), "R3", sum, int'(lvl_o));
    check(int'(lvl_o) >= -7 && int'(lvl_o) <= 7, "R10", int'(lvl_o), 7);
    if (!en_s) check(gates == 12'hCCC, "R8", int'(gates), 12'hCCC);
    if (count_on) begin
      for (int b = 0; b < 3; b++) begin
        if (gates[4*b +: 4] != prevc[b]) tcnt[b]++;
        prevc[b] = gates[4*b +: 4];
      end
      if (crossed) begin
        check(tcnt[0] == 14, "R9", tcnt[0], 14);
        check(tcnt[1] == 6, "R9", tcnt[1], 6);
        check(tcnt[2] == 2, "R9", tcnt[2], 2);
        for (int b = 0; b < 3; b++) tcnt[b] = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(int'(lvl_o) == 0, "R1", int'(lvl_o), 0);
    check(gates == 12'hCCC, "R1", int'(gates), 12'hCCC);
    rst = 0;
    // R4 R5 R6 R9 sweep every table row over a full period
    for (int r = 0; r < 4; r++) begin
      idx = 2'(r); en = 0; inc = 16'd64;
      step();
      en = 1;
      for (int b = 0; b < 3; b++) begin tcnt[b] = 0; prevc[b] = gates[4*b +: 4]; end
      count_on = 1;
      for (int i = 0; i < 1024; i++) step();
      count_on = 0;
    end
    // R4 coarse odd increment, unaligned wraps
    inc = 16'd1001; idx = 2'd1;
    for (int i = 0; i < 2000; i++) step();
    // R7 row request mid-quarter takes effect only at the crossing
    en = 0; idx = 2'd0; inc = 16'd64; step();
    en = 1;
    while (ph < 5461) step();
    idx = 2'd3;
    while (ph < 10923) step();
    check(int'(lvl_o) == 5, "R7", int'(lvl_o), 5);
    while (ph < 32768 + 10923) step();
    check(int'(lvl_o) == -6, "R7", int'(lvl_o), -6);
    // R8 enable drop mid-period, then restart from phase 0
    en = 0;
    for (int i = 0; i < 5; i++) step();
    check(int'(lvl_o) == 0, "R8", int'(lvl_o), 0);
    en = 1; idx = 2'd2;
    step();
    check(ph == 64 && int'(lvl_o) == 0, "R8", int'(lvl_o), 0);
    for (int i = 0; i < 1500; i++) step();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule